// File: doc/BRIEF.md
# Chained Vector Multiply-Add Pipeline

This block computes, element by element, `result[i] = a[i] * b[i] + c[i]` over a vector of 1 to 64 integer elements. Two pipelined functional units do the work: a multiplier with a fixed depth of 7 cycles and an adder with a fixed depth of 6 cycles. Each unit accepts one element per cycle. A single start pulse captures the three source vectors, the vector length and the chaining-mode bit. The block then runs the multiply, followed by the add that depends on it.

When chaining is on, each product element goes into the adder in the same cycle it leaves the multiplier. Nothing is buffered between the units, so the adder's work overlaps the multiplier's. When chaining is off, the products are kept in a product store. The adder begins only when the last product emerges, and then it walks the store from element 0 upward. Both modes give bit-identical results. Only the total cycle count differs, and the block reports that count so the cost of running without chaining can be seen directly.

Top module: `vmuladd_chain`

## Requirements
- R1: For every index i below the effective length L, result element i, held at bits [16i+15:16i], equals the low 16 bits of the sum of `c[i]` and the low 16 bits of `a[i]*b[i]`. Source element i sits at the same bit positions in each source vector.
- R2: With chaining on, `cycles` reports 7 + 6 + (L-1) once the operation is done, which is 76 for L = 64.
- R3: With chaining off, `cycles` reports 7 + (L-1) + 6 + (L-1) once the operation is done, which is 139 for L = 64.
- R4: For identical sources and length, the result vector is the same whether chaining is on or off.
- R5: If `start` is accepted at a rising clock edge E, `done` is low after E and first reads high after the edge that lies `cycles`+1 edges after E.
- R6: After an operation completes, every result element at an index of L or above reads zero.
- R7: A `vlen` of 0 runs as L = 1, and a `vlen` above 64 runs as L = 64. Any other value is used as given.
- R8: A `start` pulse that arrives while an operation is in progress is ignored. The running operation finishes with its original length, mode, results and cycle count.
- R9: The sources, `vlen` and `chain_en` are sampled only at the accepting edge. Changing them during an operation has no effect on its result or its cycle count.
- R10: After reset, `done` is 0, `cycles` is 0 and every result element is 0.
- R11: Once `done` is high, `done`, `cycles` and `result` hold their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; accepted only while idle |
| chain_en | input | 1 | 1 = forward products straight into the adder, 0 = adder waits for the last product |
| vlen | input | 7 | Requested element count (see R7) |
| src_a | input | 1024 | Multiplicand vector, 64 elements of 16 bits, element i at [16i+15:16i] |
| src_b | input | 1024 | Multiplier vector, same layout |
| src_c | input | 1024 | Addend vector, same layout |
| result | output | 1024 | Result vector, same layout |
| done | output | 1 | High from completion until the next accepted start |
| cycles | output | 8 | Cycle count of the last operation, from start to the cycle the final sum appears |

## Verification
The bench targets the following corner cases.

- **Length-one runs.** In unchained mode the only product must be bypassed to the adder in the same cycle it appears. A design that read the product store there would add a stale zero instead.
- **Lengths of 0 and 100.** A design without clamping would hang, or would index outside the vector.
- **Operand values that wrap.** These expose a product that is not truncated before the add.
- **A long run followed by a short one.** If the result store is not cleared, old elements remain above L.
- **Sources and `start` changed in the middle of a run.** A design that did not capture its inputs at the start would mix old and new values. One that re-launched on the second pulse would report the wrong length and cycle count.
- **Exact done edge in both modes.** Checking this catches an adder that starts one cycle early or one cycle late.

// File: rtl/vma_pkg.sv
`timescale 1ns/1ps
package vma_pkg;

    localparam int ELEM_W = 16;
    localparam int MAX_VL = 64;
    localparam int IDX_W  = $clog2(MAX_VL);
    localparam int LEN_W  = IDX_W + 1;
    localparam int VEC_W  = ELEM_W * MAX_VL;

    typedef logic [ELEM_W-1:0] elem_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [LEN_W-1:0]  len_t;

    typedef enum logic {
        FU_MUL = 1'b0,
        FU_ADD = 1'b1
    } fu_op_e;

    // element tag that travels with each operation through a unit
    typedef struct packed {
        logic vld;
        idx_t idx;
    } fu_tag_t;

    typedef struct packed {
        fu_tag_t tag;
        elem_t   data;
    } fu_tok_t;

    // map a raw request onto the supported range 1..MAX_VL
    function automatic len_t clamp_len(len_t raw);
        if (raw == '0)
            return len_t'(1);
        if (raw > len_t'(MAX_VL))
            return len_t'(MAX_VL);
        return raw;
    endfunction

    function automatic idx_t last_idx(len_t l);
        len_t m;
        m = l - len_t'(1);
        return idx_t'(m);
    endfunction

    // total cycles from accept to the cycle the final sum emerges
    function automatic int unsigned run_cycles(int unsigned len, logic chained,
                                               int unsigned mul_lat, int unsigned add_lat);
        if (chained)
            return mul_lat + add_lat + len - 1;
        return mul_lat + add_lat + 2 * (len - 1);
    endfunction

    function automatic elem_t lane_get(logic [VEC_W-1:0] v, int i);
        return v[i*ELEM_W +: ELEM_W];
    endfunction

endpackage

// File: rtl/vma_fu.sv
`timescale 1ns/1ps
module vma_fu
    import vma_pkg::*;
#(
    parameter fu_op_e OP  = FU_MUL,
    parameter int     LAT = 7
) (
    input  logic    clk,
    input  logic    rst,
    input  fu_tag_t in_tag,
    input  elem_t   in_x,
    input  elem_t   in_y,
    output fu_tok_t out_tok
);

    elem_t   res;
    fu_tok_t stage [LAT];

    generate
        if (OP == FU_MUL) begin : g_mul
            assign res = in_x * in_y;
        end else begin : g_add
            assign res = in_x + in_y;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < LAT; k++)
                stage[k] <= '0;
        end else begin
            stage[0].tag  <= in_tag;
            stage[0].data <= in_tag.vld ? res : '0;
            for (int k = 1; k < LAT; k++)
                stage[k] <= stage[k-1];
        end
    end

    assign out_tok = stage[LAT-1];

endmodule

// File: rtl/vma_seq.sv
`timescale 1ns/1ps
module vma_seq
    import vma_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             chain_en,
    input  len_t             vlen,
    input  fu_tag_t          mul_done_tag,
    input  fu_tag_t          add_done_tag,
    output logic             busy,
    output logic             launch,
    output len_t             len_q,
    output logic             chain_q,
    output fu_tag_t          mul_iss,
    output fu_tag_t          add_iss,
    output logic             add_bypass,
    output logic             done,
    output logic [CNT_W-1:0] cycles_q
);

    logic [CNT_W-1:0] cyc;
    idx_t             aidx;
    logic             unch_run;
    idx_t             lst;
    logic             last_prod;
    logic             add_go;
    logic             finish;

    assign launch    = start & ~busy;
    assign lst       = last_idx(len_q);
    assign last_prod = mul_done_tag.vld && (mul_done_tag.idx == lst);
    assign add_go    = busy && !chain_q && (unch_run || last_prod);
    assign finish    = busy && add_done_tag.vld && (add_done_tag.idx == lst);

    // multiplier issues element k during cycle k of the run
    always_comb begin
        mul_iss.vld = busy && (cyc < CNT_W'(len_q));
        mul_iss.idx = idx_t'(cyc);
    end

    // adder source: straight from the multiplier, or a walk over the store
    always_comb begin
        if (chain_q) begin
            add_iss    = mul_done_tag;
            add_bypass = 1'b1;
        end else begin
            add_iss.vld = add_go;
            add_iss.idx = aidx;
            add_bypass  = mul_done_tag.vld && (mul_done_tag.idx == aidx);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            cyc      <= '0;
            len_q    <= len_t'(1);
            chain_q  <= 1'b0;
            aidx     <= '0;
            unch_run <= 1'b0;
            done     <= 1'b0;
            cycles_q <= '0;
        end else if (launch) begin
            busy     <= 1'b1;
            cyc      <= '0;
            len_q    <= clamp_len(vlen);
            chain_q  <= chain_en;
            aidx     <= '0;
            unch_run <= 1'b0;
            done     <= 1'b0;
        end else if (busy) begin
            cyc <= cyc + CNT_W'(1);
            if (add_go) begin
                aidx     <= aidx + idx_t'(1);
                unch_run <= (aidx != lst);
            end
            if (finish) begin
                busy     <= 1'b0;
                done     <= 1'b1;
                cycles_q <= cyc;
            end
        end
    end

endmodule

// File: rtl/vma_store.sv
`timescale 1ns/1ps
module vma_store
    import vma_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic [VEC_W-1:0] src_c,
    input  idx_t             mul_idx,
    input  idx_t             add_idx,
    input  logic             add_bypass,
    input  fu_tok_t          mul_out,
    input  fu_tok_t          add_out,
    output elem_t            mul_x,
    output elem_t            mul_y,
    output elem_t            add_x,
    output elem_t            add_y,
    output logic [VEC_W-1:0] result
);

    elem_t a_q    [MAX_VL];
    elem_t b_q    [MAX_VL];
    elem_t c_q    [MAX_VL];
    elem_t prod_q [MAX_VL];
    elem_t res_q  [MAX_VL];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MAX_VL; i++) begin
                a_q[i]    <= '0;
                b_q[i]    <= '0;
                c_q[i]    <= '0;
                prod_q[i] <= '0;
                res_q[i]  <= '0;
            end
        end else if (launch) begin
            for (int i = 0; i < MAX_VL; i++) begin
                a_q[i]   <= lane_get(src_a, i);
                b_q[i]   <= lane_get(src_b, i);
                c_q[i]   <= lane_get(src_c, i);
                res_q[i] <= '0;
            end
        end else begin
            if (mul_out.tag.vld)
                prod_q[mul_out.tag.idx] <= mul_out.data;
            if (add_out.tag.vld)
                res_q[add_out.tag.idx] <= add_out.data;
        end
    end

    assign mul_x = a_q[mul_idx];
    assign mul_y = b_q[mul_idx];
    assign add_x = add_bypass ? mul_out.data : prod_q[add_idx];
    assign add_y = c_q[add_idx];

    generate
        for (genvar g = 0; g < MAX_VL; g++) begin : g_res
            assign result[g*ELEM_W +: ELEM_W] = res_q[g];
        end
    endgenerate

endmodule

// File: rtl/vmuladd_chain.sv
`timescale 1ns/1ps
module vmuladd_chain
    import vma_pkg::*;
#(
    parameter int MUL_LAT = 7,
    parameter int ADD_LAT = 6,
    localparam int CNT_W  = $clog2(MUL_LAT + ADD_LAT + 2 * MAX_VL + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             chain_en,
    input  logic [LEN_W-1:0] vlen,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic [VEC_W-1:0] src_c,
    output logic [VEC_W-1:0] result,
    output logic             done,
    output logic [CNT_W-1:0] cycles
);

    logic    busy;
    logic    launch;
    len_t    len_q;
    logic    chain_q;
    fu_tag_t mul_iss;
    fu_tag_t add_iss;
    logic    add_bypass;
    fu_tok_t mul_out;
    fu_tok_t add_out;
    elem_t   mul_x;
    elem_t   mul_y;
    elem_t   add_x;
    elem_t   add_y;

    vma_seq #(
        .CNT_W (CNT_W)
    ) seq_i (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .chain_en     (chain_en),
        .vlen         (vlen),
        .mul_done_tag (mul_out.tag),
        .add_done_tag (add_out.tag),
        .busy         (busy),
        .launch       (launch),
        .len_q        (len_q),
        .chain_q      (chain_q),
        .mul_iss      (mul_iss),
        .add_iss      (add_iss),
        .add_bypass   (add_bypass),
        .done         (done),
        .cycles_q     (cycles)
    );

    vma_store store_i (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .src_a      (src_a),
        .src_b      (src_b),
        .src_c      (src_c),
        .mul_idx    (mul_iss.idx),
        .add_idx    (add_iss.idx),
        .add_bypass (add_bypass),
        .mul_out    (mul_out),
        .add_out    (add_out),
        .mul_x      (mul_x),
        .mul_y      (mul_y),
        .add_x      (add_x),
        .add_y      (add_y),
        .result     (result)
    );

    vma_fu #(
        .OP  (FU_MUL),
        .LAT (MUL_LAT)
    ) mul_i (
        .clk     (clk),
        .rst     (rst),
        .in_tag  (mul_iss),
        .in_x    (mul_x),
        .in_y    (mul_y),
        .out_tok (mul_out)
    );

    vma_fu #(
        .OP  (FU_ADD),
        .LAT (ADD_LAT)
    ) add_i (
        .clk     (clk),
        .rst     (rst),
        .in_tag  (add_iss),
        .in_x    (add_x),
        .in_y    (add_y),
        .out_tok (add_out)
    );

endmodule

// File: rtl/vmuladd_chain_chk.sv
`timescale 1ns/1ps
module vmuladd_chain_chk
    import vma_pkg::*;
#(
    parameter int MUL_LAT = 7,
    parameter int ADD_LAT = 6,
    parameter int CNT_W   = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             done,
    input logic [CNT_W-1:0] cycles,
    input logic             busy,
    input logic             chain_q,
    input len_t             len_q,
    input fu_tag_t          mul_iss,
    input fu_tag_t          add_tag,
    input logic [VEC_W-1:0] result
);

    logic upper_zero;

    always_comb begin
        upper_zero = 1'b1;
        for (int i = 0; i < MAX_VL; i++)
            if (i >= int'(len_q) && lane_get(result, i) != '0)
                upper_zero = 1'b0;
    end

    AST_CHAIN_TIME: assert property (@(posedge clk) disable iff (rst)
        ($rose(done) && chain_q) |-> (cycles == CNT_W'(run_cycles(int'(len_q), 1'b1, MUL_LAT, ADD_LAT)))); // R2

    AST_UNCHAIN_TIME: assert property (@(posedge clk) disable iff (rst)
        ($rose(done) && !chain_q) |-> (cycles == CNT_W'(run_cycles(int'(len_q), 1'b0, MUL_LAT, ADD_LAT)))); // R3

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R5

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> upper_zero); // R6

    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy |-> (len_q >= len_t'(1) && len_q <= len_t'(MAX_VL))); // R7

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(len_q) && $stable(chain_q))); // R8

    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(cycles) && $stable(result))); // R11

    AST_MUL_ORDER: assert property (@(posedge clk) disable iff (rst)
        (mul_iss.vld && mul_iss.idx != '0) |-> ($past(mul_iss.vld) && mul_iss.idx == idx_t'($past(mul_iss.idx) + idx_t'(1)))); // R1

    AST_ADD_ORDER: assert property (@(posedge clk) disable iff (rst)
        (add_tag.vld && add_tag.idx != '0) |-> ($past(add_tag.vld) && add_tag.idx == idx_t'($past(add_tag.idx) + idx_t'(1)))); // R1

endmodule

bind vmuladd_chain vmuladd_chain_chk #(
    .MUL_LAT (MUL_LAT),
    .ADD_LAT (ADD_LAT),
    .CNT_W   (CNT_W)
) chk_i (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .done    (done),
    .cycles  (cycles),
    .busy    (busy),
    .chain_q (chain_q),
    .len_q   (len_q),
    .mul_iss (mul_iss),
    .add_tag (add_out.tag),
    .result  (result)
);

// File: tb/vmuladd_chain_tb_top.sv
`timescale 1ns/1ps
module vmuladd_chain_tb_top;
    import vma_pkg::*;

    localparam int ML    = 7;
    localparam int AL    = 6;
    localparam int CNT_W = $clog2(ML + AL + 2 * MAX_VL + 2);

    logic             clk = 1'b0;
    logic             rst;
    logic             start;
    logic             chain_en;
    logic [LEN_W-1:0] vlen;
    logic [VEC_W-1:0] src_a;
    logic [VEC_W-1:0] src_b;
    logic [VEC_W-1:0] src_c;
    logic [VEC_W-1:0] result;
    logic             done;
    logic [CNT_W-1:0] cycles;

    int n_cmp = 0;
    int n_bad = 0;

    logic [VEC_W-1:0] r_ch;
    logic [VEC_W-1:0] r_un;
    logic [VEC_W-1:0] r_tmp;
    int unsigned      seed_dummy;

    always #10 clk = ~clk;

    vmuladd_chain #(.MUL_LAT(ML), .ADD_LAT(AL)) dut_i (
        .clk(clk), .rst(rst), .start(start), .chain_en(chain_en), .vlen(vlen),
        .src_a(src_a), .src_b(src_b), .src_c(src_c),
        .result(result), .done(done), .cycles(cycles)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_vec(input string tag, input logic [VEC_W-1:0] got, input logic [VEC_W-1:0] exp);
        int bad;
        bad = -1;
        for (int i = MAX_VL - 1; i >= 0; i--)
            if (got[i*ELEM_W +: ELEM_W] != exp[i*ELEM_W +: ELEM_W])
                bad = i;
        if (bad < 0)
            check(1'b1, tag, 0, 0);
        else
            check(1'b0, $sformatf("%s element %0d", tag, bad),
                  longint'(got[bad*ELEM_W +: ELEM_W]), longint'(exp[bad*ELEM_W +: ELEM_W]));
    endtask

    function automatic int eff_len(int raw);
        if (raw == 0) return 1;
        if (raw > MAX_VL) return MAX_VL;
        return raw;
    endfunction

    function automatic int exp_cycles(int len, bit chained);
        return chained ? (ML + AL + len - 1) : (ML + (len - 1) + AL + (len - 1));
    endfunction

    function automatic logic [VEC_W-1:0] exp_vec(logic [VEC_W-1:0] a, logic [VEC_W-1:0] b,
                                                 logic [VEC_W-1:0] c, int len);
        logic [VEC_W-1:0] r;
        logic [31:0]      full;
        logic [15:0]      p;
        r = '0;
        for (int i = 0; i < len; i++) begin
            full = a[i*16 +: 16] * b[i*16 +: 16];
            p    = full[15:0];
            r[i*16 +: 16] = p + c[i*16 +: 16];
        end
        return r;
    endfunction

    task automatic fill_rand();
        for (int i = 0; i < MAX_VL; i++) begin
            src_a[i*16 +: 16] = 16'($urandom);
            src_b[i*16 +: 16] = 16'($urandom);
            src_c[i*16 +: 16] = 16'($urandom);
        end
    endtask

    // disturb: 0 none, 1 change sources and mode mid-run (R9), 2 second start mid-run (R8)
    task automatic run_op(input int raw_len, input bit chain, input int disturb,
                          input string dtag, output logic [VEC_W-1:0] got);
        logic [VEC_W-1:0] ea, eb, ec, ex;
        int L, T, n;
        @(negedge clk);
        vlen     = LEN_W'(raw_len);
        chain_en = chain;
        start    = 1'b1;
        ea = src_a; eb = src_b; ec = src_c;
        L  = eff_len(raw_len);
        T  = exp_cycles(L, chain);
        ex = exp_vec(ea, eb, ec, L);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 400) begin
            if (n == 4 && disturb == 1) begin
                src_a    = ~src_a;
                src_b    = src_b ^ {VEC_W/16{16'h5a5a}};
                src_c    = src_c + 1;
                chain_en = ~chain;
                vlen     = LEN_W'(2);
            end
            if (n == 4 && disturb == 2) begin
                start    = 1'b1;
                vlen     = LEN_W'(3);
                chain_en = ~chain;
            end
            if (n == 5 && disturb == 2)
                start = 1'b0;
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        check(n == T + 1, "R5 done edge", n, T + 1);
        check(int'(cycles) == T, chain ? "R2 chained cycles" : "R3 unchained cycles", cycles, T);
        chk_vec(dtag, result, ex);
        got = result;
    endtask

    initial begin
        #(20 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        seed_dummy = $urandom(32'd4242);
        rst = 1'b1; start = 1'b0; chain_en = 1'b0; vlen = '0;
        src_a = '0; src_b = '0; src_c = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        check(done == 1'b0, "R10 done after reset", done, 0);
        check(cycles == '0, "R10 cycles after reset", cycles, 0);
        chk_vec("R10 result after reset", result, '0);

        // full length, both modes, same data (R2, R3, R4)
        fill_rand();
        run_op(64, 1'b1, 0, "R1 chained L64", r_ch);
        run_op(64, 1'b0, 0, "R1 unchained L64", r_un);
        chk_vec("R4 mode independence L64", r_un, r_ch);

        // R11 hold after done
        repeat (20) @(negedge clk);
        check(done == 1'b1, "R11 done held", done, 1);
        check(int'(cycles) == 139, "R11 cycles held", cycles, 139);
        chk_vec("R11 result held", result, r_un);

        // length one: unchained bypass of the only product
        fill_rand();
        run_op(1, 1'b1, 0, "R1 chained L1", r_ch);
        run_op(1, 1'b0, 0, "R1 unchained L1", r_un);
        chk_vec("R4 mode independence L1", r_un, r_ch);

        // R7 clamping
        run_op(0, 1'b0, 0, "R7 vlen 0 as 1", r_tmp);
        fill_rand();
        run_op(100, 1'b1, 0, "R7 vlen 100 as 64", r_tmp);

        // wrapping operands
        src_a = '1; src_b = '1; src_c = '1;
        run_op(37, 1'b0, 0, "R1 wrap all ones", r_tmp);
        for (int i = 0; i < MAX_VL; i++) begin
            src_a[i*16 +: 16] = 16'h8000 + 16'(i);
            src_b[i*16 +: 16] = 16'h0003;
            src_c[i*16 +: 16] = 16'hfff0;
        end
        run_op(64, 1'b1, 0, "R1 wrap high bit", r_tmp);

        // R6 long run then short run
        fill_rand();
        run_op(64, 1'b1, 0, "R1 long before short", r_tmp);
        run_op(5, 1'b0, 0, "R1 short after long", r_tmp);
        check(r_tmp[VEC_W-1:5*ELEM_W] == '0, "R6 upper elements zero", longint'(r_tmp[127:80]), 0);

        // R9 inputs changed mid-run
        fill_rand();
        run_op(20, 1'b1, 1, "R9 sources changed chained", r_tmp);
        fill_rand();
        run_op(20, 1'b0, 1, "R9 sources changed unchained", r_tmp);

        // R8 second start while busy
        fill_rand();
        run_op(30, 1'b0, 2, "R8 restart ignored unchained", r_tmp);
        fill_rand();
        run_op(30, 1'b1, 2, "R8 restart ignored chained", r_tmp);

        // random lengths and modes
        for (int k = 0; k < 12; k++) begin
            int  l;
            bit  m;
            fill_rand();
            l = 1 + int'($urandom % 64);
            m = 1'($urandom);
            run_op(l, m, 0, $sformatf("R1 random L%0d", l), r_tmp);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule